// File: doc/BRIEF.md
# Data-dependent-latency shift-and-add multiplier

This block multiplies two unsigned operands and returns their full-width product. A synchronous reset captures both operands. The block then walks the multiplier operand one bit at a time, starting at its most significant bit. Each walk step doubles the running product. When the bit under inspection is set, the step also adds the multiplicand.

The time to finish depends on the data. A clear bit is handled in one clock, because only a shift is needed. A set bit takes two clocks: the first clock holds every register so the wide adder has a full cycle to settle, and the second clock captures the sum. After a reset, the result and the completion flag therefore appear after the operand width plus the number of set multiplier bits. The result and the flag then stay frozen until the next reset. To start a new operation, the user drives the operands and pulses reset.

Top module: `varlat_mul`

## Requirements
- R1: A clock edge with `rst` high captures `a_in` and `b_in`, clears `prod_out` to 0 and clears `done_out` to 0.
- R2: When the multiplier bit under inspection is 0, one clock sets `prod_out` to its previous value shifted left by one (the shifted-out top bit is dropped), and the walk moves on to the next bit.
- R3: When the multiplier bit under inspection is 1, the first clock leaves `prod_out` unchanged. The second clock loads `prod_out` with (previous `prod_out` << 1) plus the captured multiplicand, zero-extended, and the walk moves on.
- R4: Multiplier bits are consumed most significant first. After k completed steps, `prod_out` equals the captured multiplicand times the top k bits of the captured multiplier, read as an unsigned number.
- R5: Exactly W steps are run (W = 32 by default). `done_out` rises on the same edge that stores the final product, which is W + popcount(multiplier) clocks after the reset edge.
- R6: While `done_out` is 1 and `rst` is low, `prod_out` and `done_out` hold their values. Changes on `a_in` and `b_in` after the reset edge have no effect on the result.
- R7: Reset has priority over every other state. Asserting it in the middle of a walk discards that walk and starts a new one with the newly captured operands.
- R8: The final `prod_out` equals the unsigned 2W-bit product of the captured operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the operands |
| a_in | input | W | Multiplicand operand |
| b_in | input | W | Multiplier operand; its bit pattern sets the latency |
| prod_out | output | 2W | Registered running or final product |
| done_out | output | 1 | Registered completion flag |

## Verification
The patterns used are all-zero operands, all-ones operands, single set bits at the top, bottom and middle of the multiplier, alternating bit patterns and random values.
- Zero and all-ones multipliers are the fastest and slowest cases. They separate one-cycle steps from two-cycle steps and check the W and 2W latency bounds.
- A single set bit shows whether bits are consumed most significant first, and where the one stall cycle lands.
- Alternating patterns exercise back-to-back changes between the stall and shift paths.
- Scrambling the operand inputs after reset shows that only the captured values count.
- A reset issued in the middle of a walk shows that reset takes priority.

// File: rtl/varlat_mul_pkg.sv
package varlat_mul_pkg;

  // Step kinds, listed in decreasing selection priority.
  typedef enum logic [2:0] {
    K_RESET     = 3'd0,
    K_FINISHED  = 3'd1,
    K_SHIFT     = 3'd2,
    K_ADD_FIN   = 3'd3,
    K_ADD_STALL = 3'd4
  } step_kind_e;

endpackage

// File: rtl/varlat_mul_count.sv
// One-hot step tracker: no carry chain; a single marker bit walks left per step.
module varlat_mul_count #(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic last
);
  localparam logic [STEPS-1:0] START = {{(STEPS-1){1'b0}}, 1'b1};

  logic [STEPS-1:0] mark_q;

  always_ff @(posedge clk) begin
    if (rst)
      mark_q <= START;
    else if (adv)
      mark_q <= mark_q << 1;
  end

  // High while the step about to be taken is the final one.
  assign last = mark_q[STEPS-1];
endmodule

// File: rtl/varlat_mul_ctrl.sv
module varlat_mul_ctrl
  import varlat_mul_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic b_msb,
  input  logic last_step,
  output logic step_en,
  output logic use_sum,
  output logic stall_q,
  output logic done_q
);
  step_kind_e kind;

  always_comb begin
    if (rst)
      kind = K_RESET;
    else if (done_q)
      kind = K_FINISHED;
    else if (!b_msb)
      kind = K_SHIFT;
    else if (stall_q)
      kind = K_ADD_FIN;
    else
      kind = K_ADD_STALL;
  end

  assign step_en = (kind == K_SHIFT) || (kind == K_ADD_FIN);
  assign use_sum = (kind == K_ADD_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      stall_q <= (kind == K_ADD_STALL);
      done_q  <= done_q | (step_en & last_step);
    end
  end
endmodule

// File: rtl/varlat_mul_dp.sv
module varlat_mul_dp #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_en,
  input  logic           use_sum,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic           b_msb,
  output logic [W-1:0]   a_held,
  output logic [2*W-1:0] prod_q
);
  localparam int PW = 2 * W;

  logic [W-1:0]  b_q;
  logic [W-1:0]  b_d;
  logic [PW-1:0] prod_shift;
  logic [PW-1:0] prod_sum;
  logic [PW-1:0] prod_d;

  // Operand select: external value at reset, shifted copy while walking.
  assign b_d = rst ? b_in : (b_q << 1);

  assign prod_shift = prod_q << 1;
  assign prod_sum   = prod_shift + {{W{1'b0}}, a_held};
  // Product select: plain shift or adder result.
  assign prod_d     = use_sum ? prod_sum : prod_shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_held <= a_in;
      b_q    <= b_d;
      prod_q <= '0;
    end else if (step_en) begin
      b_q    <= b_d;
      prod_q <= prod_d;
    end
  end

  assign b_msb = b_q[W-1];
endmodule

// File: rtl/varlat_mul.sv
module varlat_mul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic [2*W-1:0] prod_out,
  output logic           done_out
);
  logic         b_msb;
  logic         last_step;
  logic         step_en;
  logic         use_sum;
  logic         stall_q;
  logic [W-1:0] a_held;

  varlat_mul_dp #(.W(W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .use_sum (use_sum),
    .a_in    (a_in),
    .b_in    (b_in),
    .b_msb   (b_msb),
    .a_held  (a_held),
    .prod_q  (prod_out)
  );

  varlat_mul_count #(.STEPS(W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .adv  (step_en),
    .last (last_step)
  );

  varlat_mul_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .b_msb     (b_msb),
    .last_step (last_step),
    .step_en   (step_en),
    .use_sum   (use_sum),
    .stall_q   (stall_q),
    .done_q    (done_out)
  );
endmodule

// File: rtl/varlat_mul_chk.sv
module varlat_mul_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           b_msb,
  input logic           stall_q,
  input logic           step_en,
  input logic [W-1:0]   a_held,
  input logic [2*W-1:0] prod_out,
  input logic           done_out
);
  localparam int CW = $clog2(W + 1) + 1;

  logic [CW-1:0] steps_seen;

  always_ff @(posedge clk) begin
    if (rst)
      steps_seen <= '0;
    else if (step_en)
      steps_seen <= steps_seen + 1'b1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (prod_out == '0) && !done_out);

  a_r2_zero_shift: assert property (@(posedge clk) disable iff (rst)
    (!done_out && !b_msb) |=> prod_out == ($past(prod_out) << 1));

  a_r3_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (!done_out && b_msb && !stall_q) |=> $stable(prod_out));

  a_r3_finish_adds: assert property (@(posedge clk) disable iff (rst)
    (!done_out && b_msb && stall_q) |=>
      prod_out == (($past(prod_out) << 1) + {{W{1'b0}}, $past(a_held)}));

  a_r5_done_at_full_count: assert property (@(posedge clk) disable iff (rst)
    done_out |-> steps_seen == CW'(W));

  a_r5_busy_below_count: assert property (@(posedge clk) disable iff (rst)
    !done_out |-> steps_seen < CW'(W));

  a_r6_hold_after_done: assert property (@(posedge clk) disable iff (rst)
    done_out |=> done_out && $stable(prod_out));
endmodule

bind varlat_mul varlat_mul_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .b_msb    (b_msb),
  .stall_q  (stall_q),
  .step_en  (step_en),
  .a_held   (a_held),
  .prod_out (prod_out),
  .done_out (done_out)
);

// File: tb/varlat_mul_test.sv
module varlat_mul_test;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst;
  logic [W-1:0]   a_in;
  logic [W-1:0]   b_in;
  logic [2*W-1:0] prod_out;
  logic           done_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  varlat_mul #(.W(W)) uut (
    .clk      (clk),
    .rst      (rst),
    .a_in     (a_in),
    .b_in     (b_in),
    .prod_out (prod_out),
    .done_out (done_out)
  );

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] partial(input logic [31:0] mc, input logic [31:0] mp, input int k);
    logic [63:0] top;
    top = (k == 0) ? 64'd0 : ({32'd0, mp} >> (32 - k));
    return {32'd0, mc} * top;
  endfunction

  // Behavioural model: step index and a pending-stall flag, advanced per clock.
  task automatic run_op(input logic [31:0] mc, input logic [31:0] mp,
                        input int abort_at, input string rtag);
    int k = 0;
    bit stall = 0;
    bit dm = 0;
    int lat = -1;
    string tag;
    rst = 1'b1; a_in = mc; b_in = mp;
    @(negedge clk);
    rst = 1'b0;
    chk64({rtag, " reset product"}, prod_out, 64'd0);
    chk64({rtag, " reset done"}, {63'd0, done_out}, 64'd0);
    // R6: scramble the operand inputs; only the captured values may count
    a_in = $urandom; b_in = $urandom;
    for (int c = 0; c < 80; c++) begin
      if (c == abort_at) return;
      @(posedge clk);
      if (dm) tag = "R6 hold";
      else if (!mp[31 - k]) begin
        tag = "R2 zero step"; k++;
        if (k == 32) begin dm = 1; lat = c + 1; end
      end else if (stall) begin
        tag = "R3 add finish"; k++; stall = 0;
        if (k == 32) begin dm = 1; lat = c + 1; end
      end else begin
        tag = "R3 stall"; stall = 1;
      end
      @(negedge clk);
      chk64({tag, " / R4 partial product"}, prod_out, partial(mc, mp, k));
      chk64({tag, " / R5 done flag"}, {63'd0, done_out}, {63'd0, dm});
    end
    chk64("R5 latency", 64'(lat), 64'(32 + $countones(mp)));
    chk64("R8 final product", prod_out, {32'd0, mc} * {32'd0, mp});
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; a_in = '0; b_in = '0;
    @(negedge clk);
    run_op(32'h0, 32'h0, -1, "R1");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, -1, "R1");
    run_op(32'h0000_1234, 32'h0, -1, "R1");
    run_op(32'h0, 32'hFFFF_FFFF, -1, "R1");
    run_op(32'hFFFF_FFFF, 32'h1, -1, "R1");
    run_op(32'h1, 32'h8000_0000, -1, "R1");
    for (int b = 0; b < 32; b += 5)
      run_op(32'hDEAD_BEEF, 32'h1 << b, -1, "R1");
    run_op(32'h1357_9BDF, 32'hAAAA_AAAA, -1, "R1");
    run_op(32'hFEDC_BA98, 32'h5555_5555, -1, "R1");
    // R7: abort in mid-walk, then restart with new operands
    run_op(32'h7777_0001, 32'hF0F0_F0F0, 20, "R1");
    run_op(32'h0BAD_CAFE, 32'h1234_5678, -1, "R7");
    run_op(32'h0000_0003, 32'hFFFF_0000, 3, "R1");
    run_op(32'hFFFF_FFFF, 32'h8000_0001, -1, "R7");
    for (int n = 0; n < 20; n++)
      run_op($urandom, $urandom, -1, "R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule